// File: doc/BRIEF.md
# Prepend-Routed Cell Egress Controller

This controller sits on a single clock between a cell source that only answers read requests and two consumers: a switch port and a bank of up to 31 egress PHY ports. When the source says a cell is ready, the controller pulls exactly one word, the routing word, and then stops reading for one cycle while it decodes that word. One bit of the routing word picks the destination. The low five bits name the egress port.

A switch-bound cell is handed over whole. The switch then drives the source read strobe until every remaining word of the cell has gone, overhead included. An egress-bound cell is handled by the controller alone. It drains the leftover prepend words without writing them anywhere. It then waits for the chosen port to report room and streams the 53-word cell to that port with a write enable and a start-of-cell marker. Finally it drains the postpend words. Data and parity reach the PHY bus unchanged, because the source bus is shared. The overhead counts come from static configuration pins, which are captured only while the controller is idle.

Top module: `cell_egress_router`

## Requirements
- R1: During reset and in the first cycle after it, `src_rd`, `phy_we`, `phy_soc` and `sw_ca` are all low.
- R2: With `src_ca` high in idle, `src_rd` is high for exactly one cycle, the cycle after `src_ca` is first seen. It is low in the following cycle, while the routing word is on `src_data`.
- R3: A routing word with bit 7 equal to 0 selects the switch. From the cycle after decode, `sw_ca` is high and `src_rd` follows `sw_rd` until (prepend count − 1) + 53 + postpend count reads have been accepted. `sw_ca` then drops and `phy_we` stays zero throughout.
- R4: A routing word with bit 7 equal to 1 selects egress, with the port number in bits 4:0. The remaining prepend words are read on consecutive cycles right after decode, and `phy_we` stays zero while they are read.
- R5: After the prepend words, `src_rd` stays low until `phy_ca[port]` is sampled high. Payload reading starts in the next cycle. It starts no earlier than one cycle after the last prepend read.
- R6: `phy_we` has only bit `port` set. It is high in the cycle after each of the 53 payload reads and nowhere else. `phy_soc` is high only together with the first payload word.
- R7: The postpend words are read with `src_rd` high straight after the payload, with `phy_we` low. `src_rd` then returns low.
- R8: Port number 31 is invalid. Every remaining word of such a cell is drained, and no `phy_we` bit is ever set.
- R9: `pre_cfg` and `post_cfg` are captured only while idle. Changing them during a cell has no effect on that cell.
- R10: A `pre_cfg` of 0 is treated as 1, because the routing word is always present.
- R11: `phy_data` and `phy_par` carry `src_data` and `src_par` unchanged, so each written word equals the source payload word.
- R12: The `phy_ca` bits of ports other than the selected one have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_cfg | input | 4 | Prepend words per cell (0 treated as 1) |
| post_cfg | input | 4 | Postpend words per cell |
| src_ca | input | 1 | Source has a cell ready |
| src_data | input | 8 | Source data bus, valid the cycle after a read |
| src_par | input | 1 | Source parity bit |
| src_rd | output | 1 | Read strobe to the source |
| sw_rd | input | 1 | Switch read strobe, used only while the switch owns a cell |
| sw_ca | output | 1 | Switch owns the current cell |
| phy_ca | input | 31 | Per-port cell space available |
| phy_we | output | 31 | Per-port write enable, one-hot |
| phy_soc | output | 1 | Start of cell to the PHY ports |
| phy_data | output | 8 | Data to the PHY ports |
| phy_par | output | 1 | Parity to the PHY ports |

## Verification
Every cell is traced cycle by cycle, with index 0 as the first cycle in which `src_ca` is high. The routing read is due at index 1 and the decode gap at index 2. The prepend drain runs from index 3 for (prepend − 1) cycles. Payload reads begin one cycle after the later of the end of the prepend drain and the cycle in which the bench raises the selected `phy_ca`. `phy_we`, `phy_soc` and the data are due exactly one cycle after each payload read. The bench builds the whole expected trace from these offsets and compares it, sampling on the falling edge. For switch cells it counts accepted `sw_rd` cycles against the overhead-inclusive length, and expects `sw_ca` to have fallen by the end.

// File: rtl/cer_pkg.sv
package cer_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_PRE,
    ST_WAIT,
    ST_PAY,
    ST_POST,
    ST_SWITCH,
    ST_DROP
  } cer_state_e;
endpackage

// File: rtl/cer_word_counter.sv
module cer_word_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/cer_route_decode.sv
module cer_route_decode #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int ROUTE_BIT = 7,
  parameter int PORTS     = 31
) (
  input  logic [DATA_W-1:0] word,
  output logic              to_egress,
  output logic [ADDR_W-1:0] port_addr,
  output logic              port_ok
);
  assign to_egress = word[ROUTE_BIT];
  assign port_addr = word[ADDR_W-1:0];
  assign port_ok   = (int'(port_addr) < PORTS);
endmodule

// File: rtl/cer_port_select.sv
module cer_port_select #(
  parameter int PORTS  = 31,
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORTS-1:0]  phy_ca,
  output logic [PORTS-1:0]  sel_vec,
  output logic              ca_sel
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign sel_vec[p] = (addr == ADDR_W'(p));
  end

  assign ca_sel = |(phy_ca & sel_vec);
endmodule

// File: rtl/cell_egress_router.sv
module cell_egress_router
  import cer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PORTS      = 31,
  parameter int ADDR_W     = 5,
  parameter int ROUTE_BIT  = DATA_W - 1,
  parameter int CELL_WORDS = 53,
  parameter int OVH_MAX    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        pre_cfg,
  input  logic [3:0]        post_cfg,
  input  logic              src_ca,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_par,
  output logic              src_rd,
  input  logic              sw_rd,
  output logic              sw_ca,
  input  logic [PORTS-1:0]  phy_ca,
  output logic [PORTS-1:0]  phy_we,
  output logic              phy_soc,
  output logic [DATA_W-1:0] phy_data,
  output logic              phy_par
);
  localparam int OVH_W = $clog2(OVH_MAX + 1);
  localparam int CNT_W = $clog2(CELL_WORDS + OVH_MAX + 1);

  cer_state_e         state;
  logic               own_rd;
  logic [ADDR_W-1:0]  addr_q;
  logic [OVH_W-1:0]   pre_q, post_q;
  logic [PORTS-1:0]   we_q;
  logic               soc_q;

  logic               cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0]   cnt_val, cnt, rest_words;

  logic               dec_egress, dec_ok;
  logic [ADDR_W-1:0]  dec_addr;
  logic [PORTS-1:0]   sel_vec;
  logic               ca_sel;

  cer_route_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROUTE_BIT(ROUTE_BIT), .PORTS(PORTS)
  ) u_dec (
    .word(src_data), .to_egress(dec_egress), .port_addr(dec_addr), .port_ok(dec_ok)
  );

  cer_port_select #(.PORTS(PORTS), .ADDR_W(ADDR_W)) u_sel (
    .addr(addr_q), .phy_ca(phy_ca), .sel_vec(sel_vec), .ca_sel(ca_sel)
  );

  cer_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .cnt(cnt), .last(cnt_last)
  );

  // words left after the routing word: leftover prepends, payload, postpends
  assign rest_words = CNT_W'(pre_q) - CNT_W'(1) + CNT_W'(CELL_WORDS) + CNT_W'(post_q);

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    unique case (state)
      ST_DECODE: begin
        cnt_load = 1'b1;
        if (!dec_egress || !dec_ok) cnt_val = rest_words;
        else                        cnt_val = CNT_W'(pre_q) - CNT_W'(1);
      end
      ST_WAIT: begin
        cnt_load = ca_sel;
        cnt_val  = CNT_W'(CELL_WORDS);
      end
      ST_PAY: begin
        if (cnt_last && post_q != '0) begin
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(post_q);
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_PRE, ST_POST, ST_DROP: cnt_dec = 1'b1;
      ST_SWITCH:                cnt_dec = sw_rd;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      own_rd <= 1'b0;
      addr_q <= '0;
      pre_q  <= OVH_W'(1);
      post_q <= '0;
      we_q   <= '0;
      soc_q  <= 1'b0;
    end else begin
      we_q  <= (state == ST_PAY) ? sel_vec : '0;
      soc_q <= (state == ST_PAY) && (cnt == CNT_W'(CELL_WORDS));
      unique case (state)
        ST_IDLE: begin
          own_rd <= 1'b0;
          pre_q  <= (pre_cfg == 4'd0) ? OVH_W'(1) : OVH_W'(pre_cfg);
          post_q <= OVH_W'(post_cfg);
          if (src_ca) begin
            state  <= ST_FETCH;
            own_rd <= 1'b1;
          end
        end
        ST_FETCH: begin
          own_rd <= 1'b0;
          state  <= ST_DECODE;
        end
        ST_DECODE: begin
          addr_q <= dec_addr;
          if (!dec_egress) begin
            state <= ST_SWITCH;
          end else if (!dec_ok) begin
            state  <= ST_DROP;
            own_rd <= 1'b1;
          end else if (pre_q > OVH_W'(1)) begin
            state  <= ST_PRE;
            own_rd <= 1'b1;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_PRE: begin
          if (cnt_last) begin
            state  <= ST_WAIT;
            own_rd <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (ca_sel) begin
            state  <= ST_PAY;
            own_rd <= 1'b1;
          end
        end
        ST_PAY: begin
          if (cnt_last) begin
            if (post_q != '0) begin
              state <= ST_POST;
            end else begin
              state  <= ST_IDLE;
              own_rd <= 1'b0;
            end
          end
        end
        ST_POST, ST_DROP: begin
          if (cnt_last) begin
            state  <= ST_IDLE;
            own_rd <= 1'b0;
          end
        end
        ST_SWITCH: begin
          if (sw_rd && cnt_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sw_ca    = (state == ST_SWITCH);
  assign src_rd   = own_rd | (sw_ca & sw_rd);
  assign phy_we   = we_q;
  assign phy_soc  = soc_q;
  assign phy_data = src_data;
  assign phy_par  = src_par;
endmodule

// File: rtl/cer_checker.sv
module cer_checker
  import cer_pkg::*;
#(
  parameter int PORTS = 31
) (
  input logic             clk,
  input logic             rst,
  input cer_state_e       state,
  input logic             src_rd,
  input logic             sw_ca,
  input logic [PORTS-1:0] phy_we,
  input logic             phy_soc,
  input logic             ca_sel
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!src_rd && phy_we == '0 && !phy_soc && !sw_ca));

  a_r2_decode_gap: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> !src_rd);

  a_r3_switch_no_write: assert property (@(posedge clk) disable iff (rst)
    sw_ca |-> (phy_we == '0));

  a_r5_hold_for_space: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !ca_sel) |=> !src_rd);

  a_r6_we_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phy_we));

  a_r6_we_after_read: assert property (@(posedge clk) disable iff (rst)
    (phy_we != '0) |-> $past(src_rd));

  a_r6_soc_with_we: assert property (@(posedge clk) disable iff (rst)
    phy_soc |-> (phy_we != '0));

  a_r7_post_no_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST) |=> (phy_we == '0));

  a_r8_drop_no_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DROP) |=> (phy_we == '0));
endmodule

bind cell_egress_router cer_checker #(.PORTS(PORTS)) u_cer_checker (
  .clk(clk), .rst(rst), .state(state), .src_rd(src_rd), .sw_ca(sw_ca),
  .phy_we(phy_we), .phy_soc(phy_soc), .ca_sel(ca_sel)
);

// File: tb/test_cell_egress_router.sv
`timescale 1ns/1ps
module test_cell_egress_router;
  localparam int PORTS = 31;
  localparam int CELLW = 53;
  localparam int TLEN  = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pre_cfg = 4'd1, post_cfg = 4'd0;
  logic        src_ca = 1'b0;
  logic [7:0]  src_data = 8'h00;
  logic        src_par = 1'b0;
  logic        src_rd;
  logic        sw_rd = 1'b0;
  logic        sw_ca;
  logic [PORTS-1:0] phy_ca = '0;
  logic [PORTS-1:0] phy_we;
  logic        phy_soc;
  logic [7:0]  phy_data;
  logic        phy_par;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] mem [0:127];
  logic       pmem[0:127];
  int         src_len = 0, src_idx = 0;
  bit         req = 0;

  logic             rd_t  [0:TLEN-1];
  logic [PORTS-1:0] we_t  [0:TLEN-1];
  logic             soc_t [0:TLEN-1];
  logic             swc_t [0:TLEN-1];
  logic [7:0]       dat_t [0:TLEN-1];
  logic             par_t [0:TLEN-1];

  always #2.5 clk = ~clk;

  cell_egress_router i_cell_egress_router (
    .clk(clk), .rst(rst), .pre_cfg(pre_cfg), .post_cfg(post_cfg),
    .src_ca(src_ca), .src_data(src_data), .src_par(src_par), .src_rd(src_rd),
    .sw_rd(sw_rd), .sw_ca(sw_ca), .phy_ca(phy_ca), .phy_we(phy_we),
    .phy_soc(phy_soc), .phy_data(phy_data), .phy_par(phy_par)
  );

  // slave source: word appears the cycle after a sampled read
  initial begin
    forever begin
      @(posedge clk);
      if (req && !src_ca) begin
        src_idx = 0;
        src_ca <= 1'b1;
      end else if (src_rd && src_idx < src_len) begin
        src_data <= mem[src_idx];
        src_par  <= pmem[src_idx];
        src_idx  = src_idx + 1;
        if (src_idx == src_len) src_ca <= 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cell(input bit egress, input int addr, input int pre, input int post,
                          input int kdel, input bit chg);
    int pe, len, s, tot, acc, bad;
    bit valid;
    pe    = (pre == 0) ? 1 : pre;
    len   = pe + CELLW + post;
    tot   = pe - 1 + CELLW + post;
    valid = egress && (addr < PORTS);
    for (int i = 0; i < len; i++) begin
      mem[i]  = 8'($urandom);
      pmem[i] = 1'($urandom);
    end
    mem[0] = egress ? {1'b1, 2'($urandom), 5'(addr)} : {1'b0, 7'($urandom)};
    src_len  = len;
    pre_cfg  = 4'(pre);
    post_cfg = 4'(post);
    @(negedge clk); req = 1;
    @(posedge clk);
    @(negedge clk); req = 0;
    acc = 0;
    for (int i = 0; i < TLEN; i++) begin
      logic v;
      logic [PORTS-1:0] ca;
      rd_t[i] = src_rd; we_t[i] = phy_we; soc_t[i] = phy_soc;
      swc_t[i] = sw_ca; dat_t[i] = phy_data; par_t[i] = phy_par;
      ca = PORTS'({$urandom, $urandom});
      if (valid) ca[addr] = (i >= kdel);
      phy_ca = ca;
      v = sw_ca && ($urandom_range(3) != 0);
      sw_rd = v;
      if (v) acc++;
      if (chg && i == 4) begin
        pre_cfg  = 4'($urandom_range(10));
        post_cfg = 4'($urandom_range(10));
      end
      if (i < TLEN - 1) @(negedge clk);
    end
    sw_rd = 0;
    // R2: routing read then one-cycle gap
    check(rd_t[0] == 0 && rd_t[1] == 1 && rd_t[2] == 0, "R2 routing read pattern",
          {rd_t[0], rd_t[1], rd_t[2]}, 3'b010);
    check(src_idx == len && !src_ca, "R3/R8 whole cell consumed", src_idx, len);
    if (!egress) begin
      check(swc_t[2] == 0 && swc_t[3] == 1, "R3 switch handover", {swc_t[2], swc_t[3]}, 2'b01);
      check(acc == tot, "R3 switch accepted words", acc, tot);
      check(swc_t[TLEN-1] == 0, "R3 switch released", swc_t[TLEN-1], 0);
      bad = -1;
      for (int i = 0; i < TLEN; i++) if (we_t[i] != '0 && bad < 0) bad = i;
      check(bad < 0, "R3 no PHY write for switch cell", bad, -1);
    end else if (!valid) begin
      bad = -1;
      for (int i = 0; i < TLEN; i++) begin
        logic e;
        e = (i == 1) || (i >= 3 && i < 3 + tot);
        if (rd_t[i] != e && bad < 0) bad = i;
      end
      check(bad < 0, "R8 drain read pattern", bad, -1);
      bad = -1;
      for (int i = 0; i < TLEN; i++) if (we_t[i] != '0 && bad < 0) bad = i;
      check(bad < 0, "R8 no PHY write for port 31", bad, -1);
    end else begin
      int rbad, wbad, sbad, dbad;
      s = ((pe + 2 > kdel) ? pe + 2 : kdel) + 1;
      rbad = -1; wbad = -1; sbad = -1; dbad = -1;
      for (int i = 0; i < TLEN; i++) begin
        logic er, ew;
        er = (i == 1) || (i >= 3 && i <= pe + 1) || (i >= s && i < s + CELLW + post);
        ew = (i >= s + 1) && (i <= s + CELLW);
        if (rd_t[i] != er && rbad < 0) rbad = i;
        if (we_t[i] != (ew ? (PORTS'(1) << addr) : '0) && wbad < 0) wbad = i;
        if (soc_t[i] != (i == s + 1) && sbad < 0) sbad = i;
        if (ew && (dat_t[i] != mem[pe + i - s - 1] || par_t[i] != pmem[pe + i - s - 1])
            && dbad < 0) dbad = i;
      end
      // R4 R5 R7: prepend drain, wait for selected space, postpend drain
      check(rbad < 0, "R4/R5/R7/R9/R10/R12 read pattern",
            (rbad < 0) ? 0 : rd_t[rbad], (rbad < 0) ? 0 : !rd_t[rbad]);
      check(wbad < 0, "R6 write enable one-hot timing", (wbad < 0) ? 0 : we_t[wbad], wbad);
      check(sbad < 0, "R6 start of cell on first word", sbad, s + 1);
      check(dbad < 0, "R11 data and parity unchanged",
            (dbad < 0) ? 0 : dat_t[dbad], (dbad < 0) ? 0 : mem[pe + dbad - s - 1]);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    check(!src_rd && phy_we == '0 && !phy_soc && !sw_ca, "R1 outputs low in reset",
          {src_rd, phy_soc, sw_ca}, 0);
    rst = 0;
    @(negedge clk);
    check(!src_rd && phy_we == '0 && !phy_soc && !sw_ca, "R1 outputs low after reset",
          {src_rd, phy_soc, sw_ca}, 0);
    // directed corners
    run_cell(1, 0, 1, 0, 0, 0);    // R4: no leftover prepend, R7: no postpend
    run_cell(1, 30, 10, 0, 0, 0);  // maximum prepend
    run_cell(1, 5, 3, 2, 20, 0);   // R5: late space on the selected port
    run_cell(1, 12, 0, 2, 0, 0);   // R10: zero prepend count behaves as one
    run_cell(1, 31, 2, 3, 0, 0);   // R8: invalid port
    run_cell(0, 0, 4, 5, 0, 0);    // R3: switch cell
    run_cell(1, 7, 2, 4, 3, 1);    // R9: configuration changed mid-cell
    run_cell(0, 0, 0, 0, 0, 1);    // R3 + R10 + R9
    for (int n = 0; n < 40; n++) begin
      int r, a, p, q;
      r = $urandom_range(9);
      a = (r == 0) ? 31 : $urandom_range(30);
      p = $urandom_range(6);
      q = $urandom_range(10 - ((p == 0) ? 1 : p));
      run_cell(r > 2, a, p, q, $urandom_range(12), $urandom_range(1));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule